// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches eight external input pins and turns selected level conditions or transitions on them into a single interrupt request for a small processor core. Each pin is first passed through a two-stage synchroniser. A per-pin detector then applies one of four sense modes, chosen by a 2-bit field. Edge-type events latch into a pending flag, which software clears by writing a one. Low-level requests are live and leave nothing behind. A per-pin mask and one global enable decide what reaches the core. When several pins qualify, the lowest-numbered pin is presented, together with its index.

The core pulses `irq_ack` in the cycle it takes the request. The global enable then drops, and the flag of the presented pin is cleared. A pulse on `irq_ret` at the end of the handler sets the global enable again. Software may set it earlier, through the status register, to allow nesting. The detector works from the pin level only. Software that drives the pin as an output can therefore raise its own interrupt.

A small service state machine tracks the handshake. It has three states:
- `SVC_IDLE`: no request.
- `SVC_PEND`: request shown.
- `SVC_BUSY`: handler running.

Its transitions are:
- *raise* (IDLE→PEND when a request appears)
- *withdraw* (PEND→IDLE when it vanishes)
- *accept* (PEND→BUSY, or IDLE→BUSY, on `irq_ack` with a request present)
- *nest* (BUSY→BUSY on a further accept)
- *finish* (BUSY→IDLE on `irq_ret`)

Top module: `eic_ctrl`

## Requirements
- R1: After reset, every register reads zero, the global enable is 0 and `irq_req` is low.
- R2: Each pin has a 2-bit sense field: 00 low level, 01 any change, 10 falling edge, 11 rising edge. Pin i<4 uses bits [2i+1:2i] of address 0; pin i>=4 uses bits [2(i-4)+1:2(i-4)] of address 1.
- R3: An edge-mode event sets the pin's bit in the flag register (address 3). The flag stays set while the pin is masked or the global enable is 0.
- R4: Writing address 3 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 untouched.
- R5: `irq_req` is high only when the global enable (bit 7 of address 4) is 1 and some pin with its mask bit (address 2) set is pending. With the global enable at 0 no request is shown, whatever the flags hold.
- R6: In low-level mode a pin is pending exactly while its synchronised level is 0, and its flag is never set. A low pulse that ends while requests are blocked is lost.
- R7: `irq_vec` is the lowest pin number among the qualified pending pins.
- R8: An `irq_ack` while `irq_req` is high clears the global enable and that pin's flag. `irq_ret` sets the global enable. A software write of address 4 loads bit 7 into it. Priority on a clash is ack, then return, then write.
- R9: A pin change made before clock edge k shows in the flag register after edge k+2, not earlier.
- R10: A write to a pin's sense register suppresses any event that pin would raise in the same cycle.
- R11: When an event and a clear (write-one or acceptance) hit the same flag in one cycle, the flag ends set.
- R12: The service state machine enters `SVC_BUSY` on every accepted request and leaves it only on `irq_ret`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 8 | External pin levels, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| irq_ack | input | 1 | Core accepts the request this cycle |
| irq_ret | input | 1 | Core returns from the handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 3 | Index of the presented pin |

## Verification
Two functions can land on the same flag in one cycle. One is a detected event that sets the flag. The other is a clear, either a write-one or the acceptance of that pin. A second collision pairs a sense-register write with an edge arriving at the synchroniser output. The bench times a pin change so that the write-one, or the sense write, is sampled on exactly the edge where the event is seen, two edges after the pin moved. It then reads the flag register: the flag must end set in the first case and clear in the second. The random phase also produces these overlaps at random, and each is judged against a cycle-by-cycle reference model in the bench.

// File: rtl/eic_pkg.sv
package eic_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        SVC_IDLE = 2'b00,
        SVC_PEND = 2'b01,
        SVC_BUSY = 2'b10
    } svc_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] ADDR_SENSE_LO = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_SENSE_HI = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_MASK     = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_FLAG     = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_STATUS   = 3'd4;

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/eic_sense.sv
module eic_sense
    import eic_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   lvl,
    input  sense_e mode,
    input  logic   mode_wr,
    output logic   edge_evt,
    output logic   level_req
);
    logic hist;
    logic raw_evt;

    always_ff @(posedge clk) begin
        if (!rst_n) hist <= 1'b0;
        else        hist <= lvl;
    end

    always_comb begin
        unique case (mode)
            SENSE_LOW:  raw_evt = 1'b0;
            SENSE_ANY:  raw_evt = lvl ^ hist;
            SENSE_FALL: raw_evt = hist & ~lvl;
            SENSE_RISE: raw_evt = ~hist & lvl;
            default:    raw_evt = 1'b0;
        endcase
    end

    // a mode write discards this cycle's comparison (R10)
    assign edge_evt  = raw_evt & ~mode_wr;
    assign level_req = (mode == SENSE_LOW) & ~lvl;

    a_r9_event_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        edge_evt |-> (lvl != hist));
endmodule

// File: rtl/eic_prio.sv
module eic_prio #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/eic_ctrl.sv
module eic_ctrl
    import eic_pkg::*;
#(
    parameter int N_PIN       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int VEC_W       = $clog2(N_PIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PIN-1:0]   pin_i,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [N_PIN-1:0]   wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [N_PIN-1:0]   rd_data,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec
);
    localparam int HALF = N_PIN / 2;

    logic [N_PIN-1:0] sense_lo, sense_hi, mask_q, flag_q;
    logic             gie_q;
    logic [N_PIN-1:0] lvl_s, evt, lvl_req, pend, qual;
    logic             wr_lo, wr_hi, wr_mask, wr_flag, wr_stat;
    logic             take;
    svc_e             state_q, state_d;

    assign wr_lo   = wr_en && (wr_addr == ADDR_SENSE_LO);
    assign wr_hi   = wr_en && (wr_addr == ADDR_SENSE_HI);
    assign wr_mask = wr_en && (wr_addr == ADDR_MASK);
    assign wr_flag = wr_en && (wr_addr == ADDR_FLAG);
    assign wr_stat = wr_en && (wr_addr == ADDR_STATUS);

    eic_sync #(.W(N_PIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_i),
        .q     (lvl_s)
    );

    for (genvar g = 0; g < N_PIN; g++) begin : g_pin
        sense_e mode_g;
        logic   mwr_g;
        if (g < HALF) begin : g_lo
            assign mode_g = sense_e'(sense_lo[2*g +: 2]);
            assign mwr_g  = wr_lo;
        end else begin : g_hi
            assign mode_g = sense_e'(sense_hi[2*(g-HALF) +: 2]);
            assign mwr_g  = wr_hi;
        end
        eic_sense u_sense (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl       (lvl_s[g]),
            .mode      (mode_g),
            .mode_wr   (mwr_g),
            .edge_evt  (evt[g]),
            .level_req (lvl_req[g])
        );
        assign pend[g] = (mode_g == SENSE_LOW) ? lvl_req[g] : flag_q[g];
    end

    assign qual = pend & mask_q & {N_PIN{gie_q}};

    eic_prio #(.N(N_PIN), .IDX_W(VEC_W)) u_prio (
        .req (qual),
        .any (irq_req),
        .idx (irq_vec)
    );

    assign take = irq_ack && irq_req;

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_lo <= '0;
            sense_hi <= '0;
            mask_q   <= '0;
        end else begin
            if (wr_lo)   sense_lo <= wr_data;
            if (wr_hi)   sense_hi <= wr_data;
            if (wr_mask) mask_q   <= wr_data;
        end
    end

    // pending flags: clears first, events last so an event wins (R11)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            logic [N_PIN-1:0] nxt;
            nxt = flag_q;
            if (wr_flag) nxt = nxt & ~wr_data;
            if (take)    nxt[irq_vec] = 1'b0;
            flag_q <= nxt | evt;
        end
    end

    // global enable: ack, then return, then software (R8)
    always_ff @(posedge clk) begin
        if (!rst_n)       gie_q <= 1'b0;
        else if (take)    gie_q <= 1'b0;
        else if (irq_ret) gie_q <= 1'b1;
        else if (wr_stat) gie_q <= wr_data[N_PIN-1];
    end

    // service state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SVC_IDLE;
        else        state_q <= state_d;
    end

    // service state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SVC_IDLE: if (take) state_d = SVC_BUSY;
                      else if (irq_req) state_d = SVC_PEND;
            SVC_PEND: if (take) state_d = SVC_BUSY;
                      else if (!irq_req) state_d = SVC_IDLE;
            SVC_BUSY: if (irq_ret && !take) state_d = SVC_IDLE;
            default:  state_d = SVC_IDLE;
        endcase
    end

    // register read port
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_SENSE_LO: rd_data = sense_lo;
            ADDR_SENSE_HI: rd_data = sense_hi;
            ADDR_MASK:     rd_data = mask_q;
            ADDR_FLAG:     rd_data = flag_q;
            ADDR_STATUS:   rd_data[N_PIN-1] = gie_q;
            default:       rd_data = '0;
        endcase
    end

    a_r5_no_req_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_q |-> !irq_req);
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (qual[irq_vec] && ((qual & ((N_PIN'(1) << irq_vec) - N_PIN'(1))) == '0)));
    a_r8_ack_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !gie_q);
    a_r8_ret_raises_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !take) |=> gie_q);
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flag |=> ((flag_q & $past(wr_data & ~evt)) == '0));
    a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_flag && !take) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
    a_r10_no_flag_on_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && flag_q[HALF-1:0] == '0) |=> (flag_q[HALF-1:0] == '0));
    a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (state_q == SVC_BUSY));
    a_r12_busy_until_return: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SVC_BUSY && !irq_ret) |=> (state_q == SVC_BUSY));
endmodule

// File: tb/eic_ctrl_bench.sv
module eic_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = 8'h00;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       irq_ack = 1'b0;
    logic       irq_ret = 1'b0;
    logic       irq_req;
    logic [2:0] irq_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    bit model_on = 0;

    always #2.5 clk = ~clk;

    eic_ctrl u_eic_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_ack(irq_ack),
        .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    // reference model built from the requirements
    logic [7:0] m_s1, m_s2, m_h, m_lo, m_hi, m_mask, m_flag;
    logic       m_gie;

    function automatic logic [1:0] m_mode(int i);
        return (i < 4) ? m_lo[2*i +: 2] : m_hi[2*(i-4) +: 2];
    endfunction

    function automatic logic [7:0] m_qual();
        logic [7:0] p;
        for (int i = 0; i < 8; i++) p[i] = (m_mode(i) == 2'b00) ? ~m_s2[i] : m_flag[i];
        return p & m_mask & {8{m_gie}};
    endfunction

    function automatic logic [2:0] m_vec();
        logic [7:0] q;
        q = m_qual();
        for (int i = 0; i < 8; i++) if (q[i]) return 3'(i);
        return 3'd0;
    endfunction

    function automatic logic [7:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return m_lo;
            3'd1: return m_hi;
            3'd2: return m_mask;
            3'd3: return m_flag;
            3'd4: return {m_gie, 7'b0};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_h <= 0; m_lo <= 0; m_hi <= 0;
            m_mask <= 0; m_flag <= 0; m_gie <= 0;
        end else begin
            logic [7:0] ev, nf;
            logic take, mw;
            logic [2:0] v;
            take = irq_ack && (m_qual() != 0);
            v = m_vec();
            for (int i = 0; i < 8; i++) begin
                mw = wr_en && (wr_addr == ((i < 4) ? 3'd0 : 3'd1));
                case (m_mode(i))
                    2'b01: ev[i] = m_s2[i] ^ m_h[i];
                    2'b10: ev[i] = m_h[i] & ~m_s2[i];
                    2'b11: ev[i] = ~m_h[i] & m_s2[i];
                    default: ev[i] = 1'b0;
                endcase
                if (mw) ev[i] = 1'b0;
            end
            nf = m_flag;
            if (wr_en && wr_addr == 3'd3) nf = nf & ~wr_data;
            if (take) nf[v] = 1'b0;
            m_flag <= nf | ev;
            if (take) m_gie <= 1'b0;
            else if (irq_ret) m_gie <= 1'b1;
            else if (wr_en && wr_addr == 3'd4) m_gie <= wr_data[7];
            if (wr_en && wr_addr == 3'd0) m_lo <= wr_data;
            if (wr_en && wr_addr == 3'd1) m_hi <= wr_data;
            if (wr_en && wr_addr == 3'd2) m_mask <= wr_data;
            m_s1 <= pin_i; m_s2 <= m_s1; m_h <= m_s2;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        rd_addr = a; #0.5; d = rd_data;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ack();
        @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
    endtask

    task automatic pulse_ret();
        @(negedge clk); irq_ret = 1; @(negedge clk); irq_ret = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // model comparison every cycle while enabled
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            logic [7:0] d;
            chk("R5 req vs model", 32'(irq_req), 32'(m_qual() != 0));
            if (m_qual() != 0) chk("R7 vec vs model", 32'(irq_vec), 32'(m_vec()));
            d = rd_data;
            chk("R3 R4 R8 read vs model", 32'(d), 32'(m_read(rd_addr)));
        end
    end

    initial begin
        #(5ns * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5eed_1234));
        wait_n(4);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        chk("R1 irq_req", 32'(irq_req), 0);
        for (int a = 0; a < 5; a++) begin rd(3'(a), d); chk("R1 reg zero", 32'(d), 0); end

        model_on = 1;
        // R2 R3 R9: pin0 falling edge, masked, disabled
        wr(3'd0, 8'h02);
        wr(3'd2, 8'h00);
        pin_i[0] = 1; wait_n(4);
        rd(3'd3, d); chk("R2 rise ignored in fall mode", 32'(d), 0);
        @(negedge clk); pin_i[0] = 0;
        wait_n(2); rd(3'd3, d); chk("R9 flag not before k+2", 32'(d), 0);
        wait_n(1); rd(3'd3, d); chk("R9 R3 flag after k+2", 32'(d), 32'h01);
        wait_n(3); rd(3'd3, d); chk("R3 flag held while blocked", 32'(d), 32'h01);
        chk("R5 masked no req", 32'(irq_req), 0);
        // R5 mask then enable
        wr(3'd2, 8'h01);
        chk("R5 gie off no req", 32'(irq_req), 0);
        wr(3'd4, 8'h80);
        chk("R5 req with gie", 32'(irq_req), 1);
        chk("R7 vec pin0", 32'(irq_vec), 0);
        // R8 accept then return
        pulse_ack();
        rd(3'd4, d); chk("R8 gie cleared on accept", 32'(d), 0);
        rd(3'd3, d); chk("R8 flag cleared on accept", 32'(d), 0);
        chk("R8 req gone", 32'(irq_req), 0);
        pulse_ret();
        rd(3'd4, d); chk("R8 gie set on return", 32'(d), 32'h80);

        // R4 write one to clear
        wr(3'd0, 8'h16);              // pin0 fall, pin1 any, pin2 any
        pin_i[1] = 1; pin_i[2] = 1; wait_n(4);
        rd(3'd3, d); chk("R4 two flags set", 32'(d), 32'h06);
        wr(3'd3, 8'h02);
        rd(3'd3, d); chk("R4 only written bit cleared", 32'(d), 32'h04);

        // R7 priority between pin2 and pin5
        wr(3'd1, 8'h0C);              // pin5 rising, others low level
        pin_i[5] = 1; pin_i[4] = 1; pin_i[6] = 1; pin_i[7] = 1; wait_n(4);
        wr(3'd2, 8'h24);
        chk("R7 lowest pin wins", 32'(irq_vec), 2);
        wr(3'd3, 8'h04);
        chk("R7 next pin", 32'(irq_vec), 5);
        wr(3'd3, 8'h20);
        chk("R7 none left", 32'(irq_req), 0);

        // R6 level mode pulse lost while disabled
        wr(3'd2, 8'h10);
        wr(3'd4, 8'h00);
        pin_i[4] = 0; wait_n(3);
        chk("R6 level blocked by gie", 32'(irq_req), 0);
        pin_i[4] = 1; wait_n(3);
        wr(3'd4, 8'h80);
        chk("R6 lost low pulse", 32'(irq_req), 0);
        rd(3'd3, d); chk("R6 no flag in level mode", 32'(d), 0);
        pin_i[4] = 0; wait_n(2);
        chk("R6 live level request", 32'(irq_req), 1);
        chk("R6 vec pin4", 32'(irq_vec), 4);
        pin_i[4] = 1; wait_n(2);
        chk("R6 request ends with level", 32'(irq_req), 0);
        wr(3'd2, 8'h00);

        // R10 sense write coinciding with the edge on pin0
        wr(3'd0, 8'h15);              // pins 0..2 any change
        @(negedge clk); pin_i[0] = 1;
        @(negedge clk); @(negedge clk);
        wr_en = 1; wr_addr = 3'd0; wr_data = 8'h15;
        @(negedge clk); wr_en = 0;
        rd(3'd3, d); chk("R10 event suppressed on mode write", 32'(d & 8'h01), 0);

        // R11 event and write-one-clear in the same cycle on pin1
        @(negedge clk); pin_i[1] = 0;
        @(negedge clk); @(negedge clk);
        wr_en = 1; wr_addr = 3'd3; wr_data = 8'h02;
        @(negedge clk); wr_en = 0;
        rd(3'd3, d); chk("R11 event beats clear", 32'(d & 8'h02), 32'h02);
        wr(3'd3, 8'hFF);

        // R12 and random phase, judged against the model
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            wr_en = 0; irq_ack = 0; irq_ret = 0;
            if ($urandom_range(0, 3) == 0) pin_i = pin_i ^ 8'($urandom_range(0, 255));
            rd_addr = 3'($urandom_range(0, 5));
            if ($urandom_range(0, 7) == 0) begin
                wr_en = 1; wr_addr = 3'($urandom_range(0, 4)); wr_data = 8'($urandom_range(0, 255));
            end
            if (irq_req && $urandom_range(0, 2) == 0) irq_ack = 1;
            if ($urandom_range(0, 11) == 0) irq_ret = 1;
        end
        @(negedge clk); wr_en = 0; irq_ack = 0; irq_ret = 0;
        wait_n(2);
        finish_run();
    end
endmodule